// File: doc/BRIEF.md
# Embedded Operation Status Read Path

This block sits on the read-data path of a byte-wide nonvolatile memory macro. While an internal program or erase operation is running, array reads cannot be served, so the block replaces the array byte with a completion status byte. The host polls this byte to learn when the operation is done.

The status byte has two indicators. The polling bit shows the complement of the pending program byte's top bit during a program, and a constant zero during any erase. The toggle bit changes value once per completed host read access. When the operation ends, both indicators stop and the true array byte is passed through again.

The busy window and the operation type come from the operation sequencer. The pending byte comes from the program data latch, and the array byte comes from the sense path. The host read strobes are active-low chip enable and output enable, sampled in the block's clock domain. The read data output is registered, so every change appears one clock after the input change that causes it.

Top module: `fsp_status_read`

## Requirements
- R1: While `rst_n` is low, `rd_data` is 0, and the toggle state is cleared. The first status byte after reset therefore shows 0 in bit 6.
- R2: While `busy` is 0, `rd_data` equals the `array_data` value sampled at the previous rising clock edge.
- R3: While `busy` is 1 and `op_erase` is 0 (program), bit 7 of `rd_data` is the inverse of bit 7 of `last_data`, one clock later.
- R4: While `busy` is 1 and `op_erase` is 1 (any erase), bit 7 of `rd_data` is 0, one clock later.
- R5: While `busy` is 1, bits 5 to 0 of `rd_data` are 0.
- R6: A read access is active when `ce_n` and `oe_n` are both low. While `busy` is 1, each end of an active access (the clock where access goes from active to inactive) inverts bit 6 of the status byte. The new bit 6 is visible on `rd_data` two clocks after the strobe release is sampled.
- R7: An access ends by releasing `ce_n` alone, `oe_n` alone, or both, and each form counts once.
- R8: While `busy` is 1, bit 6 does not change during an access held active for many clocks, nor while strobes stay inactive.
- R9: While `busy` is 0, the toggle state is held at 0, so the first read of every operation returns 0 in bit 6.
- R10: The first read after `busy` falls returns the complete true array byte, including bits 7 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | High while a program or erase operation runs |
| op_erase | input | 1 | Operation type: 0 = program, 1 = erase |
| last_data | input | DATA_W | Byte most recently loaded for programming |
| array_data | input | DATA_W | Byte read from the array |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| rd_data | output | DATA_W | Read data to the host (status or array byte) |

## Verification
The bench builds the block with its defaults: an 8-bit bus, the polling indicator on bit 7, the toggle indicator on bit 6, and the registered output. This makes the exact positions of both indicators observable. It also exercises the one-clock output latency, so the two-clock delay from a strobe release to a new toggle value is checked at its exact cycle. Reads end by each of the three strobe release forms. The bench also uses long reads held during busy, program bytes with either top-bit value, and a back-to-back operation that must restart the toggle at 0.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  typedef enum logic {
    OPK_PROGRAM = 1'b0,
    OPK_ERASE   = 1'b1
  } op_kind_e;

endpackage

// File: rtl/fsp_access_edge.sv
// Tracks the combined host read enable and flags the clock in which an
// access finishes (either strobe, or both, released).
module fsp_access_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  output logic access_end
);

  logic rd_act;
  logic rd_q;
  logic rd_d;

  always_comb begin
    rd_act     = ~ce_n & ~oe_n;
    rd_d       = rd_act;
    access_end = rd_q & ~rd_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
    end else begin
      rd_q <= rd_d;
    end
  end

endmodule

// File: rtl/fsp_toggle_reg.sv
// Toggle state: flips on each completed access while busy, cleared when idle.
module fsp_toggle_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic access_end,
  output logic tog_q
);

  logic tog_d;
  logic tog_en;

  always_comb begin
    tog_en = ~busy | access_end;
    tog_d  = busy ? ~tog_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else if (tog_en) begin
      tog_q <= tog_d;
    end
  end

endmodule

// File: rtl/fsp_status_mux.sv
// Builds the status byte while busy, the array byte otherwise.
module fsp_status_mux
  import fsp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              busy,
  input  op_kind_e          op_kind,
  input  logic [DATA_W-1:0] last_data,
  input  logic [DATA_W-1:0] array_data,
  input  logic              tog_q,
  output logic [DATA_W-1:0] stat
);

  logic poll_val;

  always_comb begin
    poll_val = (op_kind == OPK_ERASE) ? 1'b0 : ~last_data[POLL_BIT];
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      always_comb stat[i] = busy ? poll_val : array_data[i];
    end else if (i == TOGGLE_BIT) begin : g_tog
      always_comb stat[i] = busy ? tog_q : array_data[i];
    end else begin : g_zero
      always_comb stat[i] = busy ? 1'b0 : array_data[i];
    end
  end

endmodule

// File: rtl/fsp_status_read.sv
module fsp_status_read
  import fsp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6,
  parameter bit REG_OUT    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              op_erase,
  input  logic [DATA_W-1:0] last_data,
  input  logic [DATA_W-1:0] array_data,
  input  logic              ce_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rd_data
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  initial begin
    if (POLL_BIT >= DATA_W || TOGGLE_BIT >= DATA_W || POLL_BIT == TOGGLE_BIT)
      $error("fsp_status_read: bad indicator bit positions (IDX_W=%0d)", IDX_W);
  end

  logic              access_end;
  logic              tog_q;
  logic [DATA_W-1:0] stat;
  op_kind_e          op_kind;

  always_comb op_kind = op_kind_e'(op_erase);

  fsp_access_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .access_end (access_end)
  );

  fsp_toggle_reg u_tog (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .access_end (access_end),
    .tog_q      (tog_q)
  );

  fsp_status_mux #(
    .DATA_W     (DATA_W),
    .POLL_BIT   (POLL_BIT),
    .TOGGLE_BIT (TOGGLE_BIT)
  ) u_mux (
    .busy       (busy),
    .op_kind    (op_kind),
    .last_data  (last_data),
    .array_data (array_data),
    .tog_q      (tog_q),
    .stat       (stat)
  );

  if (REG_OUT) begin : g_reg_out
    logic [DATA_W-1:0] out_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q <= '0;
      end else begin
        out_q <= stat;
      end
    end
    always_comb rd_data = out_q;
  end else begin : g_comb_out
    always_comb rd_data = stat;
  end

endmodule

// File: rtl/fsp_status_read_chk.sv
module fsp_status_read_chk #(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6,
  parameter bit REG_OUT    = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              op_erase,
  input logic [DATA_W-1:0] last_data,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              tog_q,
  input logic              access_end
);

  localparam logic [DATA_W-1:0] IND_MASK =
    (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOGGLE_BIT);

  // R6: a completed access while busy inverts the toggle state
  a_r6_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && access_end) |=> (tog_q != $past(tog_q)));

  // R8: no completed access while busy, no change
  a_r8_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !access_end) |=> $stable(tog_q));

  // R9: idle clears the toggle state
  a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (tog_q == 1'b0));

  if (REG_OUT) begin : g_reg_chk
    a_r2_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> (rd_data == $past(array_data)));

    a_r3_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !op_erase) |=> (rd_data[POLL_BIT] == ~$past(last_data[POLL_BIT])));

    a_r4_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_erase) |=> (rd_data[POLL_BIT] == 1'b0));

    a_r5_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ((rd_data & ~IND_MASK) == '0));
  end

endmodule

bind fsp_status_read fsp_status_read_chk #(
  .DATA_W     (DATA_W),
  .POLL_BIT   (POLL_BIT),
  .TOGGLE_BIT (TOGGLE_BIT),
  .REG_OUT    (REG_OUT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .op_erase   (op_erase),
  .last_data  (last_data),
  .array_data (array_data),
  .rd_data    (rd_data),
  .tog_q      (tog_q),
  .access_end (access_end)
);

// File: tb/tb_fsp_status_read.sv
`timescale 1ns/1ps
module tb_fsp_status_read;

  logic       clk;
  logic       rst_n;
  logic       busy;
  logic       op_erase;
  logic [7:0] last_data;
  logic [7:0] array_data;
  logic       ce_n;
  logic       oe_n;
  logic [7:0] rd_data;

  int    n_chk;
  int    n_fail;
  bit    done;
  string cur_req;

  fsp_status_read dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .op_erase   (op_erase),
    .last_data  (last_data),
    .array_data (array_data),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .rd_data    (rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference: count of completed accesses, queue for latency
  int         m_acc_cnt;
  bit         m_was_rd;
  logic [7:0] m_pipe[$];
  logic [7:0] m_exp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc_cnt = 0;
      m_was_rd  = 0;
      m_pipe.delete();
      m_exp     = 8'h00;
    end else begin
      logic [7:0] v;
      bit now_rd;
      now_rd = (ce_n == 1'b0) && (oe_n == 1'b0);
      if (busy) begin
        v    = 8'h00;
        v[7] = op_erase ? 1'b0 : ~last_data[7];
        v[6] = (m_acc_cnt % 2) == 1;
      end else begin
        v = array_data;
      end
      m_pipe.push_back(v);
      m_exp = m_pipe.pop_front();
      if (!busy) m_acc_cnt = 0;
      else if (m_was_rd && !now_rd) m_acc_cnt = m_acc_cnt + 1;
      m_was_rd = now_rd;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) check(cur_req, rd_data, m_exp);
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // mode 0: both strobes, 1: ce_n only, 2: oe_n only; returns byte seen mid-read
  task automatic rd_access(input int mode, input int hold, output logic [7:0] seen);
    ce_n = 1'b0; oe_n = 1'b0;
    repeat (hold) @(posedge clk);
    @(negedge clk); seen = rd_data;
    @(posedge clk); #1;
    if (mode == 0) begin ce_n = 1'b1; oe_n = 1'b1; end
    else if (mode == 1) ce_n = 1'b1;
    else oe_n = 1'b1;
    tick();
  endtask

  initial begin
    logic [7:0] s;
    logic [7:0] prev;
    n_chk = 0; n_fail = 0; done = 0;
    cur_req = "R1";
    rst_n = 1'b0; busy = 1'b0; op_erase = 1'b0;
    last_data = 8'h00; array_data = 8'hA5; ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); check("R1", rd_data, 8'h00);
    #1 rst_n = 1'b1;

    // R2 idle passthrough, several patterns
    cur_req = "R2";
    array_data = 8'h3C; tick();
    array_data = 8'hFF; tick();
    array_data = 8'h00; tick();
    rd_access(0, 2, s); check("R2", s, 8'h00);
    array_data = 8'h96; tick(); tick();

    // R3 program, top bit 0 -> poll 1; R1 first status after reset bit6 0
    cur_req = "R3";
    last_data = 8'h5A; busy = 1'b1; op_erase = 1'b0; tick();
    rd_access(0, 2, s); check("R1", {1'b0, s[6], 6'h0}, 8'h00);
    check("R3", s, 8'h80);
    rd_access(0, 2, s); check("R6", s, 8'hC0);
    rd_access(0, 2, s); check("R6", s, 8'h80);
    // R7 ce_n only / oe_n only releases
    cur_req = "R7";
    rd_access(1, 2, s); check("R7", s, 8'hC0);
    rd_access(2, 2, s); check("R7", s, 8'h80);
    rd_access(2, 2, s); check("R7", s, 8'hC0);
    // R8 long read and quiet period: bit6 unchanged
    cur_req = "R8";
    ce_n = 1'b0; oe_n = 1'b0;
    tick(); @(negedge clk); prev = rd_data;
    repeat (20) tick();
    @(negedge clk); check("R8", rd_data, prev);
    ce_n = 1'b1; oe_n = 1'b1; tick();
    repeat (10) tick();
    @(negedge clk); check("R8", rd_data, {1'b1, ~prev[6], 6'h0});
    // R3 with top bit 1 -> poll 0; R5 other bits zero
    cur_req = "R3";
    last_data = 8'hC3; tick();
    rd_access(0, 2, s); check("R5", s & 8'h3F, 8'h00);
    check("R3", s[7], 1'b0);

    // R10 first read after busy falls is the true byte
    cur_req = "R10";
    array_data = 8'h7B; busy = 1'b0; tick();
    rd_access(0, 1, s); check("R10", s, 8'h7B);

    // R4 erase, R9 toggle restarts at 0
    cur_req = "R4";
    array_data = 8'h12; op_erase = 1'b1; last_data = 8'h00; busy = 1'b1; tick();
    rd_access(1, 1, s); check("R9", s, 8'h00);
    rd_access(2, 1, s); check("R4", s, 8'h40);
    rd_access(0, 3, s); check("R4", s, 8'h00);
    cur_req = "R10";
    array_data = 8'hFF; busy = 1'b0; tick();
    rd_access(0, 1, s); check("R10", s, 8'hFF);

    // back-to-back: short idle, new program starts with bit6 0
    cur_req = "R9";
    busy = 1'b1; op_erase = 1'b0; last_data = 8'h01; tick();
    rd_access(0, 1, s); check("R9", s, 8'h80);
    busy = 1'b0; array_data = 8'h44; tick(); tick();

    // R1 reset mid-operation clears state
    cur_req = "R1";
    busy = 1'b1; rd_access(0, 1, s);
    rst_n = 1'b0; #1;
    check("R1", rd_data, 8'h00);
    tick(); rst_n = 1'b1; tick();
    rd_access(0, 1, s); check("R1", s, 8'h80);
    busy = 1'b0; tick(); tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule